// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block makes the per-transaction decision for the device side of a USB function that has a small number of endpoints. A packet receiver in front of it delivers checked tokens (kind, endpoint number, CRC5 verdict), data packets (PID, CRC16 verdict, payload) and the host's handshake after an IN. The block combines these with the live state of each endpoint: halted, OUT buffer occupied, IN packet queued, and transfer type. It then returns the PID to transmit (DATA0, DATA1, ACK, NAK, STALL) or stays silent.

The block keeps an IN and an OUT data toggle for each endpoint. It emits a write strobe that loads an accepted OUT or SETUP payload into that endpoint's buffer. It also emits a completion pulse when a queued IN packet may be released. Control, bulk, interrupt and isochronous endpoints each follow their own response rules. Serial transmission and request decoding sit outside the block.

Top module: `usb_ep_responder`

## Requirements
- R1: A token with `tok_ok`=0, or a data packet with `dat_ok`=0, produces no response, no write and no toggle change; a data packet arriving without an accepted OUT/SETUP token is ignored.
- R2: SETUP (`tok_kind`=2) to a control endpoint (type 0) followed by a good DATA0 (PID 4'h3) is answered ACK (4'h2) and written, even when the endpoint is halted or its buffer is full; it sets both toggles of that endpoint, so the next IN is sent as DATA1 (4'hB) and the next OUT is expected as DATA1.
- R3: A SETUP data packet carrying DATA1 gets no response and is not written.
- R4: OUT (`tok_kind`=0) with good data on a bulk (1), interrupt (2) or control endpoint answers STALL (4'hE) if halted, else NAK (4'hA) if its buffer is full, else ACK.
- R5: An ACKed OUT whose PID matches the OUT toggle (DATA0 for toggle 0) is written and flips the toggle; a mismatching one is ACKed but neither written nor flipped.
- R6: IN (`tok_kind`=1) on a non-isochronous endpoint answers STALL if halted, NAK if nothing is queued, else DATA0/DATA1 per its IN toggle; the toggle flips and `in_done` pulses only when the host then returns ACK (4'h2).
- R7: An isochronous endpoint (type 3) never handshakes: IN returns DATA0 with `in_done` at once when data is queued and nothing otherwise; OUT data is written when the buffer is empty and never answered; no toggle is used.
- R8: Tokens to an endpoint number at or above the implemented count (NUM_EP, capped at 3 when LOW_SPEED=1 and at 16 otherwise) get no response.
- R9: SETUP to a non-control endpoint is ignored, as is its data packet.
- R10: After reset all strobes are low; every response, write and completion appears on the first rising edge after the input that causes it, and a token alone yields no output for OUT/SETUP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 ignored |
| tok_ep | input | 4 | Endpoint number |
| tok_ok | input | 1 | Token CRC5 good |
| dat_valid | input | 1 | Data packet strobe |
| dat_pid | input | 4 | Data packet PID |
| dat_ok | input | 1 | Data packet CRC16 good |
| dat_payload | input | PAY_W | Packet payload |
| hs_valid | input | 1 | Host handshake strobe |
| hs_pid | input | 4 | Host handshake PID |
| ep_halt | input | NUM_EP | Halt bit per endpoint |
| ep_out_full | input | NUM_EP | OUT buffer occupied per endpoint |
| ep_in_ready | input | NUM_EP | IN packet queued per endpoint |
| ep_kind | input | 2*NUM_EP | Transfer type per endpoint (0 control, 1 bulk, 2 interrupt, 3 isochronous) |
| rsp_valid | output | 1 | Transmit a packet |
| rsp_pid | output | 4 | PID to transmit |
| wr_en | output | 1 | Load payload into endpoint buffer |
| wr_ep | output | 4 | Endpoint being loaded |
| wr_data | output | PAY_W | Payload being loaded |
| in_done | output | 1 | Queued IN packet delivered |
| in_done_ep | output | 4 | Endpoint whose IN packet was delivered |

## Verification
The bench sweeps every combination of halt, buffer-full and data PID on the bulk and interrupt endpoints, and every combination of halt, queued data and host reply for IN. It follows the toggles in its own model. A design that ranked NAK above STALL, wrote a repeated OUT, or advanced an IN toggle on a NAK would show a wrong PID, a spurious write or a DATA0/DATA1 slip a few transactions later. The control sequence checks that SETUP is ACKed while halted and full, and that it forces the next IN to DATA1. Corrupt packets, isochronous traffic, unknown endpoints and SETUP on a bulk endpoint must all stay silent; a design that leaked a handshake there would show a response strobe where none is allowed.

// File: rtl/usbr_pkg.sv
package usbr_pkg;
  localparam logic [3:0] PID_DATA0 = 4'h3;
  localparam logic [3:0] PID_DATA1 = 4'hB;
  localparam logic [3:0] PID_ACK   = 4'h2;
  localparam logic [3:0] PID_NAK   = 4'hA;
  localparam logic [3:0] PID_STALL = 4'hE;

  typedef enum logic [1:0] {TK_OUT = 2'd0, TK_IN = 2'd1, TK_SETUP = 2'd2, TK_RSVD = 2'd3} tok_kind_t;
  typedef enum logic [1:0] {XF_CTRL = 2'd0, XF_BULK = 2'd1, XF_INTR = 2'd2, XF_ISO = 2'd3} xfer_t;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_DATA = 2'd1, PH_HS = 2'd2} phase_t;
endpackage

// File: rtl/usbr_toggle_bank.sv
module usbr_toggle_bank #(
  parameter int N_EP = 4,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   ep,
  input  logic            seed,
  input  logic            flip_in,
  input  logic            flip_out,
  output logic [N_EP-1:0] in_tog,
  output logic [N_EP-1:0] out_tog
);
  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    logic hit;
    assign hit = (ep == IW'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        in_tog[i]  <= 1'b0;
        out_tog[i] <= 1'b0;
      end else if (hit && seed) begin
        in_tog[i]  <= 1'b1;
        out_tog[i] <= 1'b1;
      end else begin
        if (hit && flip_in)  in_tog[i]  <= ~in_tog[i];
        if (hit && flip_out) out_tog[i] <= ~out_tog[i];
      end
    end
  end
endmodule

// File: rtl/usbr_rules.sv
module usbr_rules
  import usbr_pkg::*;
(
  input  xfer_t      in_xf,
  input  logic       in_halt,
  input  logic       in_ready,
  input  logic       in_tog,
  input  xfer_t      out_xf,
  input  logic       out_halt,
  input  logic       out_full,
  input  logic       out_tog,
  input  logic       out_setup,
  input  logic [3:0] out_pid,
  output logic       in_rsp,
  output logic [3:0] in_pid,
  output logic       in_fin,
  output logic       out_rsp,
  output logic [3:0] out_rpid,
  output logic       out_wr,
  output logic       out_flip,
  output logic       out_seed
);
  // IN token decision
  always_comb begin
    in_rsp = 1'b0;
    in_pid = PID_DATA0;
    in_fin = 1'b0;
    if (in_xf == XF_ISO) begin
      in_rsp = in_ready;
      in_fin = in_ready;
    end else if (in_halt) begin
      in_rsp = 1'b1;
      in_pid = PID_STALL;
    end else if (!in_ready) begin
      in_rsp = 1'b1;
      in_pid = PID_NAK;
    end else begin
      in_rsp = 1'b1;
      in_pid = in_tog ? PID_DATA1 : PID_DATA0;
    end
  end

  // good data packet after OUT or SETUP
  always_comb begin
    out_rsp  = 1'b0;
    out_rpid = PID_ACK;
    out_wr   = 1'b0;
    out_flip = 1'b0;
    out_seed = 1'b0;
    if (out_setup) begin
      if (out_pid == PID_DATA0) begin
        out_rsp  = 1'b1;
        out_wr   = 1'b1;
        out_seed = 1'b1;
      end
    end else if (out_xf == XF_ISO) begin
      out_wr = !out_full;
    end else if (out_halt) begin
      out_rsp  = 1'b1;
      out_rpid = PID_STALL;
    end else if (out_full) begin
      out_rsp  = 1'b1;
      out_rpid = PID_NAK;
    end else begin
      out_rsp = 1'b1;
      if ((out_pid == PID_DATA1) == out_tog) begin
        out_wr   = 1'b1;
        out_flip = 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
  import usbr_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int PAY_W     = 16,
  parameter bit LOW_SPEED = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tok_valid,
  input  logic [1:0]          tok_kind,
  input  logic [3:0]          tok_ep,
  input  logic                tok_ok,
  input  logic                dat_valid,
  input  logic [3:0]          dat_pid,
  input  logic                dat_ok,
  input  logic [PAY_W-1:0]    dat_payload,
  input  logic                hs_valid,
  input  logic [3:0]          hs_pid,
  input  logic [NUM_EP-1:0]   ep_halt,
  input  logic [NUM_EP-1:0]   ep_out_full,
  input  logic [NUM_EP-1:0]   ep_in_ready,
  input  logic [2*NUM_EP-1:0] ep_kind,
  output logic                rsp_valid,
  output logic [3:0]          rsp_pid,
  output logic                wr_en,
  output logic [3:0]          wr_ep,
  output logic [PAY_W-1:0]    wr_data,
  output logic                in_done,
  output logic [3:0]          in_done_ep
);
  localparam int EP_LIMIT = LOW_SPEED ? 3 : 16;
  localparam int N_EP     = (NUM_EP > EP_LIMIT) ? EP_LIMIT : NUM_EP;
  localparam int IW       = (N_EP > 1) ? $clog2(N_EP) : 1;

  phase_t        phase;
  logic [IW-1:0] cur_ep;
  logic          cur_setup;

  logic          tok_hit;
  logic [IW-1:0] tep;
  xfer_t         tok_xf, cur_xf;
  tok_kind_t     tk;
  logic          pid_is_data;
  logic          dat_take, hs_take;

  logic [N_EP-1:0] in_tog, out_tog;

  logic       a_in_rsp, a_in_fin, a_out_rsp, a_out_wr, a_out_flip, a_out_seed;
  logic [3:0] a_in_pid, a_out_pid;

  assign tk          = tok_kind_t'(tok_kind);
  assign tok_hit     = ({1'b0, tok_ep} < 5'(N_EP));
  assign tep         = tok_hit ? tok_ep[IW-1:0] : '0;
  assign pid_is_data = (dat_pid == PID_DATA0) || (dat_pid == PID_DATA1);
  assign dat_take    = !tok_valid && dat_valid && (phase == PH_DATA);
  assign hs_take     = !tok_valid && !dat_take && hs_valid && (phase == PH_HS);

  always_comb begin
    tok_xf = xfer_t'(ep_kind[2*int'(tep) +: 2]);
    cur_xf = xfer_t'(ep_kind[2*int'(cur_ep) +: 2]);
  end

  usbr_rules u_rules (
    .in_xf    (tok_xf),
    .in_halt  (ep_halt[tep]),
    .in_ready (ep_in_ready[tep]),
    .in_tog   (in_tog[tep]),
    .out_xf   (cur_xf),
    .out_halt (ep_halt[cur_ep]),
    .out_full (ep_out_full[cur_ep]),
    .out_tog  (out_tog[cur_ep]),
    .out_setup(cur_setup),
    .out_pid  (dat_pid),
    .in_rsp   (a_in_rsp),
    .in_pid   (a_in_pid),
    .in_fin   (a_in_fin),
    .out_rsp  (a_out_rsp),
    .out_rpid (a_out_pid),
    .out_wr   (a_out_wr),
    .out_flip (a_out_flip),
    .out_seed (a_out_seed)
  );

  logic good_dat;
  assign good_dat = dat_take && dat_ok && pid_is_data;

  usbr_toggle_bank #(.N_EP(N_EP), .IW(IW)) u_tog (
    .clk     (clk),
    .rst     (rst),
    .ep      (cur_ep),
    .seed    (good_dat && a_out_seed),
    .flip_in (hs_take && (hs_pid == PID_ACK)),
    .flip_out(good_dat && a_out_flip),
    .in_tog  (in_tog),
    .out_tog (out_tog)
  );

  always_ff @(posedge clk) begin
    rsp_valid <= 1'b0;
    wr_en     <= 1'b0;
    in_done   <= 1'b0;
    if (rst) begin
      phase      <= PH_IDLE;
      cur_ep     <= '0;
      cur_setup  <= 1'b0;
      rsp_pid    <= PID_NAK;
      wr_ep      <= '0;
      wr_data    <= '0;
      in_done_ep <= '0;
    end else if (tok_valid) begin
      phase <= PH_IDLE;
      if (tok_ok && tok_hit) begin
        cur_ep <= tep;
        case (tk)
          TK_IN: begin
            rsp_valid  <= a_in_rsp;
            rsp_pid    <= a_in_pid;
            in_done    <= a_in_fin;
            in_done_ep <= 4'(tep);
            if (a_in_rsp && (tok_xf != XF_ISO) && (a_in_pid != PID_NAK) && (a_in_pid != PID_STALL))
              phase <= PH_HS;
          end
          TK_OUT: begin
            phase     <= PH_DATA;
            cur_setup <= 1'b0;
          end
          TK_SETUP: begin
            if (tok_xf == XF_CTRL) begin
              phase     <= PH_DATA;
              cur_setup <= 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end else if (dat_take) begin
      phase <= PH_IDLE;
      if (dat_ok && pid_is_data) begin
        rsp_valid <= a_out_rsp;
        rsp_pid   <= a_out_pid;
        wr_en     <= a_out_wr;
        wr_ep     <= 4'(cur_ep);
        wr_data   <= dat_payload;
      end
    end else if (hs_take) begin
      phase <= PH_IDLE;
      if (hs_pid == PID_ACK) begin
        in_done    <= 1'b1;
        in_done_ep <= 4'(cur_ep);
      end
    end
  end

  AST_CORRUPT_TOKEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(tok_valid && !tok_ok) |-> (!rsp_valid && !wr_en)); // R1
  AST_CORRUPT_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(dat_valid && !tok_valid && !dat_ok) |-> (!rsp_valid && !wr_en)); // R1
  AST_SETUP_ONLY_ACK: assert property (@(posedge clk) disable iff (rst)
    ($past(dat_valid && !tok_valid && (phase == PH_DATA) && cur_setup) && rsp_valid) |-> (rsp_pid == PID_ACK)); // R2
  AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rsp_valid) |-> (rsp_pid == PID_ACK)); // R5
  AST_ISO_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    ($past(tok_valid && tok_ok && tok_hit && (tok_kind == 2'd1) && (tok_xf == XF_ISO)) && rsp_valid) |-> (rsp_pid == PID_DATA0)); // R7
  AST_UNKNOWN_EP_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(tok_valid && !tok_hit) |-> !rsp_valid); // R8
endmodule

// File: tb/tb_usb_ep_responder.sv
`timescale 1ns/100ps
module tb_usb_ep_responder;
  localparam int NE = 4;
  localparam int PW = 16;

  logic clk = 0, rst = 1;
  logic tok_valid = 0, tok_ok = 0, dat_valid = 0, dat_ok = 0, hs_valid = 0;
  logic [1:0] tok_kind = 0;
  logic [3:0] tok_ep = 0, dat_pid = 0, hs_pid = 0;
  logic [PW-1:0] dat_payload = 0;
  logic [NE-1:0] halt = 0, full = 0, ready = 0;
  logic [2*NE-1:0] kinds = 8'b11_10_01_00;
  logic rsp_valid, wr_en, in_done;
  logic [3:0] rsp_pid, wr_ep, in_done_ep;
  logic [PW-1:0] wr_data;

  int total = 0, bad = 0;
  bit finished = 0;
  logic btin [NE];
  logic btout [NE];

  always #2.5 clk = ~clk;

  usb_ep_responder #(.NUM_EP(NE), .PAY_W(PW)) dut (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ep(tok_ep),
    .tok_ok(tok_ok), .dat_valid(dat_valid), .dat_pid(dat_pid), .dat_ok(dat_ok),
    .dat_payload(dat_payload), .hs_valid(hs_valid), .hs_pid(hs_pid), .ep_halt(halt),
    .ep_out_full(full), .ep_in_ready(ready), .ep_kind(kinds), .rsp_valid(rsp_valid),
    .rsp_pid(rsp_pid), .wr_en(wr_en), .wr_ep(wr_ep), .wr_data(wr_data),
    .in_done(in_done), .in_done_ep(in_done_ep));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tok(logic [1:0] k, logic [3:0] ep, logic ok);
    @(negedge clk);
    tok_valid = 1; tok_kind = k; tok_ep = ep; tok_ok = ok;
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic dat(logic [3:0] pid, logic ok, logic [PW-1:0] pl);
    @(negedge clk);
    dat_valid = 1; dat_pid = pid; dat_ok = ok; dat_payload = pl;
    @(negedge clk);
    dat_valid = 0;
  endtask

  task automatic hs(logic [3:0] pid);
    @(negedge clk);
    hs_valid = 1; hs_pid = pid;
    @(negedge clk);
    hs_valid = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin btin[i] = 0; btout[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset rsp", rsp_valid, 0);
    chk("R10 reset wr", wr_en, 0);
    chk("R10 reset done", in_done, 0);

    // OUT sweep on bulk and interrupt endpoints
    for (int ep = 1; ep <= 2; ep++)
      for (int h = 0; h < 2; h++)
        for (int f = 0; f < 2; f++)
          for (int p = 0; p < 2; p++) begin
            logic [PW-1:0] pl;
            logic [3:0] ep_pid;
            logic ew;
            pl = PW'(ep * 4096 + h * 256 + f * 16 + p + 7);
            halt[ep] = h[0]; full[ep] = f[0];
            tok(2'd0, 4'(ep), 1);
            chk("R10 OUT token silent", rsp_valid, 0);
            dat(p[0] ? 4'hB : 4'h3, 1, pl);
            ep_pid = h[0] ? 4'hE : (f[0] ? 4'hA : 4'h2);
            ew = !h[0] && !f[0] && (p[0] == btout[ep]);
            chk("R4 OUT rsp", rsp_valid, 1);
            chk("R4 OUT pid", rsp_pid, ep_pid);
            chk("R5 OUT write", wr_en, ew);
            if (ew) begin
              chk("R5 OUT data", wr_data, pl);
              chk("R5 OUT ep", wr_ep, ep);
              btout[ep] = !btout[ep];
            end
          end
    halt = 0; full = 0;

    // IN sweep
    for (int ep = 1; ep <= 2; ep++)
      for (int h = 0; h < 2; h++)
        for (int r = 0; r < 2; r++)
          for (int a = 0; a < 2; a++) begin
            logic [3:0] ep_pid;
            halt[ep] = h[0]; ready[ep] = r[0];
            tok(2'd1, 4'(ep), 1);
            ep_pid = h[0] ? 4'hE : (!r[0] ? 4'hA : (btin[ep] ? 4'hB : 4'h3));
            chk("R6 IN rsp", rsp_valid, 1);
            chk("R6 IN pid", rsp_pid, ep_pid);
            chk("R6 IN no early done", in_done, 0);
            if (!h[0] && r[0]) begin
              hs(a[0] ? 4'h2 : 4'hA);
              chk("R6 IN done on ACK", in_done, a[0]);
              if (a[0]) begin
                chk("R6 IN done ep", in_done_ep, ep);
                btin[ep] = !btin[ep];
              end
            end
          end
    halt = 0; ready = 0;

    // control endpoint: SETUP while halted and full
    halt[0] = 1; full[0] = 1;
    tok(2'd2, 0, 1);
    chk("R10 SETUP token silent", rsp_valid, 0);
    dat(4'h3, 1, 16'h8006);
    chk("R2 SETUP rsp", rsp_valid, 1);
    chk("R2 SETUP ack", rsp_pid, 4'h2);
    chk("R2 SETUP write", wr_en, 1);
    chk("R2 SETUP data", wr_data, 16'h8006);
    halt[0] = 0; full[0] = 0; ready[0] = 1;
    tok(2'd1, 0, 1);
    chk("R2 data stage DATA1", rsp_pid, 4'hB);
    hs(4'h2);
    chk("R6 ctrl done", in_done, 1);
    tok(2'd1, 0, 1);
    chk("R6 ctrl next DATA0", rsp_pid, 4'h3);
    hs(4'hA);
    ready[0] = 0;
    tok(2'd0, 0, 1);
    dat(4'hB, 1, 16'h0001);
    chk("R2 OUT after SETUP expects DATA1", wr_en, 1);
    chk("R2 OUT ack", rsp_pid, 4'h2);
    tok(2'd2, 0, 1);
    dat(4'hB, 1, 16'h1234);
    chk("R3 SETUP DATA1 silent", rsp_valid, 0);
    chk("R3 SETUP DATA1 no write", wr_en, 0);

    // corrupt packets (ep1 out toggle currently btout[1])
    tok(2'd0, 1, 0);
    chk("R1 bad token silent", rsp_valid, 0);
    dat(btout[1] ? 4'hB : 4'h3, 1, 16'h5555);
    chk("R1 stray data silent", rsp_valid, 0);
    chk("R1 stray data no write", wr_en, 0);
    tok(2'd0, 1, 1);
    dat(btout[1] ? 4'hB : 4'h3, 0, 16'h6666);
    chk("R1 bad data silent", rsp_valid, 0);
    chk("R1 bad data no write", wr_en, 0);
    tok(2'd0, 1, 1);
    dat(btout[1] ? 4'hB : 4'h3, 1, 16'h7777);
    chk("R1 toggle kept after bad data", wr_en, 1);
    btout[1] = !btout[1];

    // isochronous endpoint 3
    ready[3] = 1;
    tok(2'd1, 3, 1);
    chk("R7 iso IN DATA0", rsp_pid, 4'h3);
    chk("R7 iso IN done", in_done, 1);
    tok(2'd1, 3, 1);
    chk("R7 iso IN still DATA0", rsp_pid, 4'h3);
    ready[3] = 0;
    tok(2'd1, 3, 1);
    chk("R7 iso IN empty silent", rsp_valid, 0);
    tok(2'd0, 3, 1);
    dat(4'hB, 1, 16'hABCD);
    chk("R7 iso OUT no handshake", rsp_valid, 0);
    chk("R7 iso OUT write", wr_en, 1);
    chk("R7 iso OUT ep", wr_ep, 3);
    full[3] = 1;
    tok(2'd0, 3, 1);
    dat(4'h3, 1, 16'hABCE);
    chk("R7 iso OUT full dropped", wr_en, 0);
    chk("R7 iso OUT full silent", rsp_valid, 0);
    full[3] = 0;

    // unknown endpoint and SETUP to bulk
    ready = '1;
    tok(2'd1, 5, 1);
    chk("R8 unknown ep IN silent", rsp_valid, 0);
    tok(2'd0, 9, 1);
    dat(4'h3, 1, 16'h0);
    chk("R8 unknown ep OUT silent", rsp_valid, 0);
    tok(2'd2, 1, 1);
    dat(4'h3, 1, 16'h0);
    chk("R9 SETUP on bulk silent", rsp_valid, 0);
    chk("R9 SETUP on bulk no write", wr_en, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule